// File: doc/BRIEF.md
# Half-Bridge Switch Control with Fault Latching

This block sits behind a serial control port and drives six half-bridges, each a high-side and a low-side power switch. It holds the last committed 16-bit control word and turns the requested switches on. It also applies the protective shutdowns: inhibit, short circuit, supply undervoltage and overtemperature. From the switch states and the fault latches it builds a 16-bit status word, which the serial port shifts back out.

A load strobe commits a new control word. The hardware run pin and the control word's run bit together decide between standby and normal operation. A short-circuit timer runs for each switch and counts a half-millisecond tick, so it can remove a shorted switch after a short delay or a long one. Short-circuit, undervoltage and overtemperature faults are latched. Writing a control word with its clear bit set releases those latches.

Top module: `hbridge_guard`

## Requirements
- R1: Reset loads the control word with bits 15, 14 and 13 high and all other bits low. Both outputs are zero during reset. After reset, with no word loaded, the status word shows no open-load flags and reads zero.
- R2: Control bits 1 to 12 request the switches. Bit 2k-1 requests the low side of output k and bit 2k requests its high side. Switch j drives swEn[j-1] and status bit j. In normal operation a status bit reads high when its switch is on. A loaded word takes effect on the outputs two clock edges after the edge that samples the load strobe.
- R3: If both sides of one half-bridge are requested, both stay off, and the other half-bridges are not affected.
- R4: Standby holds when control bit 15 is low or hwRunPin is low. In standby all switches are off and status bit 14 reads high. A change on hwRunPin reaches the outputs one edge after it is sampled.
- R5: A short flag held on a switch that is on makes the switch's timer count tickPulse cycles. The switch is latched off on the 3rd tick when control bit 14 is low, and on the 24th tick when it is high. If the flag drops, the count restarts from zero.
- R6: A switch latched off by a short stays off after its flag clears. Status bit 13 stays high while any switch is latched off. Both hold until a word with bit 0 high is loaded.
- R7: supplyLow sets a latch. The latch forces all switches off and sets status bit 15, two edges after supplyLow is sampled. Loading bit 0 high clears it.
- R8: tempShut sets a latch. The latch forces all switches off and makes all 16 status bits read high, two edges after tempShut is sampled. Loading bit 0 high clears it.
- R9: Status bit 0 follows tempWarn one edge later, unless the overtemperature latch is set.
- R10: When control bit 13 is low, the status bit of a switch that is off shows openLoad for its output, with high meaning open. The status bit of a switch that is on still reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 16 | Control word from the serial port |
| cfgLoad | input | 1 | Commit strobe for cfgWord |
| hwRunPin | input | 1 | Hardware run pin, low selects standby |
| shortFlag | input | 12 | Per-switch short flag, same index as swEn |
| openLoad | input | 6 | Per-output open-load comparator, high means open |
| tempWarn | input | 1 | Temperature prewarning |
| tempShut | input | 1 | Overtemperature shutdown request |
| supplyLow | input | 1 | Supply undervoltage |
| tickPulse | input | 1 | One-cycle pulse every 0.5 ms |
| swEn | output | 12 | Switch enables; index 2k is the low side and 2k+1 the high side of output k+1 |
| statusWord | output | 16 | Status word for the serial port |

## Verification
Each result has a fixed latency. A committed control word and a latched fault reach swEn and statusWord two edges after their input is sampled. The run pin, tempWarn and openLoad reach them one edge after sampling. A short removes its switch one edge after the tick that completes its delay. The bench steps a behavioural model at every rising edge with exactly these latencies and compares both outputs at every falling edge. Directed checks wait several cycles past each latency before they read a fixed expected word.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // Strobes from the control side to the output datapath.
  typedef struct packed {
    logic swRun;       // software run bit (low = standby)
    logic openLoadEn;  // open-load reporting enabled
    logic uvHold;      // undervoltage latch
    logic otHold;      // overtemperature latch
    logic scAny;       // any switch latched off by a short
  } hbg_strobe_t;
endpackage

// File: rtl/hbg_sc_timer.sv
module hbg_sc_timer #(
  parameter int FAST_TICKS = 3,
  parameter int SLOW_TICKS = 24,
  localparam int CNT_W = $clog2(SLOW_TICKS + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic slowSel,
  input  logic shorted,
  input  logic isOn,
  input  logic tick,
  output logic trip
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   limit;
  logic [CNT_W:0]   nextCnt;
  logic             armed;

  always_comb begin
    limit   = slowSel ? (CNT_W+1)'(SLOW_TICKS) : (CNT_W+1)'(FAST_TICKS);
    nextCnt = {1'b0, cnt} + 1'b1;
    armed   = shorted && isOn && !clear;
    trip    = armed && tick && (nextCnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!armed) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= trip ? '0 : nextCnt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/hbg_ctrl.sv
module hbg_ctrl import hbg_pkg::*; #(
  parameter int N_OUT = 6,
  parameter int FAST_TICKS = 3,
  parameter int SLOW_TICKS = 24,
  localparam int NSW = 2 * N_OUT,
  localparam int WORD_W = NSW + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic              cfgLoad,
  input  logic [NSW-1:0]    shortFlag,
  input  logic              supplyLow,
  input  logic              tempShut,
  input  logic              tickPulse,
  input  logic [NSW-1:0]    swEn,
  output hbg_strobe_t       strb,
  output logic [NSW-1:0]    reqOn,
  output logic [NSW-1:0]    scOff
);
  localparam int CLR_BIT = 0;
  localparam int OLD_BIT = NSW + 1;
  localparam int DLY_BIT = NSW + 2;
  localparam int RUN_BIT = NSW + 3;
  localparam logic [WORD_W-1:0] RESET_WORD = {3'b111, {(NSW + 1){1'b0}}};

  logic [WORD_W-1:0] ctrlReg;
  logic [NSW-1:0]    scHold;
  logic [NSW-1:0]    trip;
  logic              uvHold;
  logic              otHold;
  logic              clr;

  assign clr = cfgLoad && cfgWord[CLR_BIT];

  for (genvar j = 0; j < NSW; j++) begin : gTimer
    hbg_sc_timer #(.FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) uTimer (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (clr),
      .slowSel(ctrlReg[DLY_BIT]),
      .shorted(shortFlag[j]),
      .isOn   (swEn[j]),
      .tick   (tickPulse),
      .trip   (trip[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= RESET_WORD;
      scHold  <= '0;
      uvHold  <= 1'b0;
      otHold  <= 1'b0;
    end else begin
      if (cfgLoad) ctrlReg <= cfgWord;
      scHold <= (scHold & ~{NSW{clr}}) | trip;
      uvHold <= (uvHold && !clr) || supplyLow;
      otHold <= (otHold && !clr) || tempShut;
    end
  end

  always_comb begin
    reqOn           = ctrlReg[NSW:1];
    scOff           = scHold;
    strb.swRun      = ctrlReg[RUN_BIT];
    strb.openLoadEn = !ctrlReg[OLD_BIT];
    strb.uvHold     = uvHold;
    strb.otHold     = otHold;
    strb.scAny      = |scHold;
  end
endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath import hbg_pkg::*; #(
  parameter int N_OUT = 6,
  localparam int NSW = 2 * N_OUT,
  localparam int WORD_W = NSW + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbg_strobe_t       strb,
  input  logic [NSW-1:0]    reqOn,
  input  logic [NSW-1:0]    scOff,
  input  logic              hwRunPin,
  input  logic [N_OUT-1:0]  openLoad,
  input  logic              tempWarn,
  output logic [NSW-1:0]    swEn,
  output logic [WORD_W-1:0] statusWord
);
  logic              standby;
  logic              stopAll;
  logic [NSW-1:0]    enNext;
  logic [NSW-1:0]    swStat;
  logic [WORD_W-1:0] statNext;

  assign standby = !strb.swRun || !hwRunPin;
  assign stopAll = standby || strb.uvHold || strb.otHold;

  for (genvar k = 0; k < N_OUT; k++) begin : gBridge
    logic clash;
    assign clash = reqOn[2*k] && reqOn[2*k+1];
    for (genvar s = 0; s < 2; s++) begin : gSide
      assign enNext[2*k+s] = reqOn[2*k+s] && !clash && !scOff[2*k+s] && !stopAll;
      assign swStat[2*k+s] = (strb.openLoadEn && !enNext[2*k+s]) ? openLoad[k]
                                                                  : enNext[2*k+s];
    end
  end

  always_comb begin
    if (strb.otHold) begin
      statNext = '1;
    end else begin
      statNext = {strb.uvHold, standby, strb.scAny, swStat, tempWarn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swEn       <= '0;
      statusWord <= '0;
    end else begin
      swEn       <= enNext;
      statusWord <= statNext;
    end
  end
endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard import hbg_pkg::*; #(
  parameter int N_OUT = 6,
  parameter int FAST_TICKS = 3,
  parameter int SLOW_TICKS = 24,
  localparam int NSW = 2 * N_OUT,
  localparam int WORD_W = NSW + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic              cfgLoad,
  input  logic              hwRunPin,
  input  logic [NSW-1:0]    shortFlag,
  input  logic [N_OUT-1:0]  openLoad,
  input  logic              tempWarn,
  input  logic              tempShut,
  input  logic              supplyLow,
  input  logic              tickPulse,
  output logic [NSW-1:0]    swEn,
  output logic [WORD_W-1:0] statusWord
);
  hbg_strobe_t    strb;
  logic [NSW-1:0] reqOn;
  logic [NSW-1:0] scOff;

  hbg_ctrl #(.N_OUT(N_OUT), .FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWord  (cfgWord),
    .cfgLoad  (cfgLoad),
    .shortFlag(shortFlag),
    .supplyLow(supplyLow),
    .tempShut (tempShut),
    .tickPulse(tickPulse),
    .swEn     (swEn),
    .strb     (strb),
    .reqOn    (reqOn),
    .scOff    (scOff)
  );

  hbg_datapath #(.N_OUT(N_OUT)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqOn     (reqOn),
    .scOff     (scOff),
    .hwRunPin  (hwRunPin),
    .openLoad  (openLoad),
    .tempWarn  (tempWarn),
    .swEn      (swEn),
    .statusWord(statusWord)
  );
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int N_OUT = 6,
  localparam int NSW = 2 * N_OUT,
  localparam int WORD_W = NSW + 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hwRunPin,
  input logic              tempWarn,
  input logic              tempShut,
  input logic              supplyLow,
  input logic [NSW-1:0]    swEn,
  input logic [WORD_W-1:0] statusWord
);
  localparam logic [NSW-1:0] LOW_SIDES = {N_OUT{2'b01}};

  assert_no_shoot_through_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((swEn >> 1) & swEn & LOW_SIDES) == '0);

  assert_pin_standby_R4: assert property (@(posedge clk) disable iff (!rstN)
    !hwRunPin |=> (swEn == '0 && statusWord[NSW+2]));

  assert_undervolt_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |-> ##2 (swEn == '0 && statusWord[NSW+3]));

  assert_overtemp_ones_R8: assert property (@(posedge clk) disable iff (!rstN)
    tempShut |-> ##2 (swEn == '0 && statusWord == '1));

  assert_prewarn_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    tempWarn |=> statusWord[0]);
endmodule

bind hbridge_guard hbg_checker #(.N_OUT(N_OUT)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .hwRunPin  (hwRunPin),
  .tempWarn  (tempWarn),
  .tempShut  (tempShut),
  .supplyLow (supplyLow),
  .swEn      (swEn),
  .statusWord(statusWord)
);

// File: tb/tb_hbridge_guard.sv
module tb_hbridge_guard;
  localparam int FAST = 3;
  localparam int SLOW = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cfgWord = '0;
  logic        cfgLoad = 1'b0;
  logic        hwRunPin = 1'b1;
  logic [11:0] shortFlag = '0;
  logic [5:0]  openLoad = '0;
  logic        tempWarn = 1'b0;
  logic        tempShut = 1'b0;
  logic        supplyLow = 1'b0;
  logic        tickPulse = 1'b0;
  logic        tickOn = 1'b0;
  logic [11:0] swEn;
  logic [15:0] statusWord;

  always #4 clk = ~clk;

  hbridge_guard dut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .cfgLoad(cfgLoad),
    .hwRunPin(hwRunPin), .shortFlag(shortFlag), .openLoad(openLoad),
    .tempWarn(tempWarn), .tempShut(tempShut), .supplyLow(supplyLow),
    .tickPulse(tickPulse), .swEn(swEn), .statusWord(statusWord)
  );

  int    total = 0;
  int    bad = 0;
  string curReq = "R1";

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model.
  logic [15:0] mCtrl, mStat, st;
  logic [11:0] mEn, mSc, newEn, scSet;
  logic        mUv, mOt, clr, sb, ls, hs;
  int          mCnt[12];
  int          lim;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 16'hE000; mSc = '0; mUv = 0; mOt = 0; mEn = '0; mStat = '0;
      for (int j = 0; j < 12; j++) mCnt[j] = 0;
    end else begin
      clr = cfgLoad && cfgWord[0];
      lim = mCtrl[14] ? SLOW : FAST;
      scSet = '0;
      for (int j = 0; j < 12; j++) begin
        if (clr || !shortFlag[j] || !mEn[j]) mCnt[j] = 0;
        else if (tickPulse) begin
          if (mCnt[j] + 1 >= lim) begin scSet[j] = 1'b1; mCnt[j] = 0; end
          else mCnt[j] = mCnt[j] + 1;
        end
      end
      sb = !mCtrl[15] || !hwRunPin;
      for (int k = 0; k < 6; k++) begin
        ls = mCtrl[2*k+1];
        hs = mCtrl[2*k+2];
        newEn[2*k]   = ls && !(ls && hs) && !mSc[2*k]   && !sb && !mUv && !mOt;
        newEn[2*k+1] = hs && !(ls && hs) && !mSc[2*k+1] && !sb && !mUv && !mOt;
      end
      st[0] = tempWarn;
      for (int j = 0; j < 12; j++)
        st[j+1] = (!mCtrl[13] && !newEn[j]) ? openLoad[j/2] : newEn[j];
      st[13] = |mSc;
      st[14] = sb;
      st[15] = mUv;
      if (mOt) st = 16'hFFFF;
      mEn = newEn;
      mStat = st;
      mSc = (clr ? 12'h000 : mSc) | scSet;
      mUv = (mUv && !clr) || supplyLow;
      mOt = (mOt && !clr) || tempShut;
      if (cfgLoad) mCtrl = cfgWord;
    end
  end

  // Compare on every falling edge.
  initial begin
    forever begin
      @(negedge clk);
      chk(curReq, "swEn model", {4'h0, swEn}, {4'h0, mEn});
      chk(curReq, "status model", statusWord, mStat);
    end
  end

  // Half-millisecond tick source: one pulse every 4 cycles when enabled.
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tickPulse = tickOn && (tc % 4 == 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk);
    cfgWord = w; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  initial begin
    // R1: reset state and defaults
    curReq = "R1";
    openLoad = 6'h3F;
    idle(3);
    chk("R1", "swEn in reset", {4'h0, swEn}, 16'h0000);
    chk("R1", "status in reset", statusWord, 16'h0000);
    rstN = 1'b1;
    idle(4);
    chk("R1", "status after reset, open-load hidden", statusWord, 16'h0000);
    openLoad = '0;

    // R2: enable mapping, LS1 + HS2 + HS6
    curReq = "R2";
    load(16'hF012);
    idle(3);
    chk("R2", "swEn mapping", {4'h0, swEn}, 16'h0809);
    chk("R2", "status mirrors switches", statusWord, 16'h1012);

    // R3: LS3 and HS3 together
    curReq = "R3";
    load(16'hE062);
    idle(3);
    chk("R3", "clash keeps bridge off", {4'h0, swEn}, 16'h0001);

    // R4: standby via pin and via software bit
    curReq = "R4";
    hwRunPin = 1'b0;
    idle(2);
    chk("R4", "pin standby swEn", {4'h0, swEn}, 16'h0000);
    chk("R4", "pin standby status", statusWord, 16'h4000);
    hwRunPin = 1'b1;
    idle(2);
    chk("R4", "pin released", {4'h0, swEn}, 16'h0001);
    load(16'h6062);
    idle(3);
    chk("R4", "software standby status", statusWord, 16'h4000);

    // R5/R6: fast short on HS2
    curReq = "R5";
    load(16'hB012);
    idle(3);
    tickOn = 1'b1;
    shortFlag[3] = 1'b1;
    idle(20);
    chk("R5", "fast short trips HS2", {4'h0, swEn}, 16'h0801);
    chk("R5", "short status bit", statusWord, 16'h3002);
    curReq = "R6";
    shortFlag[3] = 1'b0;
    idle(6);
    chk("R6", "stays off after flag clears", {4'h0, swEn}, 16'h0801);
    load(16'hB013);
    idle(3);
    chk("R6", "clear restores HS2", {4'h0, swEn}, 16'h0809);
    chk("R6", "clear drops short bit", statusWord, 16'h1012);

    // R5: slow delay on LS1, with a dropout that restarts the count
    curReq = "R5";
    load(16'hF012);
    idle(2);
    shortFlag[0] = 1'b1;
    idle(40);
    shortFlag[0] = 1'b0;
    idle(2);
    shortFlag[0] = 1'b1;
    idle(70);
    chk("R5", "slow short still on", {4'h0, swEn}, 16'h0809);
    idle(40);
    chk("R5", "slow short trips LS1", {4'h0, swEn}, 16'h0808);
    shortFlag[0] = 1'b0;
    load(16'hF013);
    idle(3);
    chk("R6", "clear restores LS1", {4'h0, swEn}, 16'h0809);
    tickOn = 1'b0;

    // R7: undervoltage
    curReq = "R7";
    load(16'hE002);
    idle(2);
    supplyLow = 1'b1;
    @(negedge clk);
    supplyLow = 1'b0;
    idle(3);
    chk("R7", "undervoltage swEn", {4'h0, swEn}, 16'h0000);
    chk("R7", "undervoltage status", statusWord, 16'h8000);
    load(16'hE003);
    idle(3);
    chk("R7", "undervoltage cleared", statusWord, 16'h0002);

    // R8: overtemperature
    curReq = "R8";
    tempShut = 1'b1;
    @(negedge clk);
    tempShut = 1'b0;
    idle(3);
    chk("R8", "overtemp status all ones", statusWord, 16'hFFFF);
    chk("R8", "overtemp swEn", {4'h0, swEn}, 16'h0000);
    load(16'hE003);
    idle(3);
    chk("R8", "overtemp cleared", {4'h0, swEn}, 16'h0001);

    // R9: prewarning
    curReq = "R9";
    tempWarn = 1'b1;
    idle(2);
    chk("R9", "prewarning bit", statusWord, 16'h0003);
    tempWarn = 1'b0;

    // R10: open-load reporting
    curReq = "R10";
    openLoad = 6'b000011;
    load(16'hC002);
    idle(3);
    chk("R10", "open-load status", statusWord, 16'h001E);
    openLoad = 6'b000000;
    idle(2);
    chk("R10", "open-load gone", statusWord, 16'h0002);

    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule